// File: doc/BRIEF.md
# Interrupt Affinity Routing Register File

This block holds one 64-bit routing entry for each shared interrupt of an interrupt controller and turns the processor affinity stored in each entry into a target processor index. Software reaches the entries over a simple register bus that carries either 32-bit or 64-bit accesses. The entry for interrupt ID `n` sits at byte offset `n * 8`. Only the three low affinity bytes (bits 23:0) are kept. The upper 32-bit word of every entry reads as zero and ignores writes.

A table of per-processor affinity values comes in on an input port. When a write to an entry is accepted, the block compares the new affinity with every table slot in the same clock edge that stores it. It then records which processor the interrupt routes to, or records a miss. The delivery logic downstream reads a target index and a valid flag for every shared interrupt in parallel. The private interrupt IDs below the shared range have no entry, and neither do IDs above the implemented count. Their slots read as zero and ignore writes.

Top module: `irq_affinity_router`

## Requirements
- R1: After reset every `route_ok` bit is 0, every `route_cpu` field is 0, and a read of any entry returns 0.
- R2: A read request is decoded as ID = `bus_addr[ADDR_W-1:3]`, word select = `bus_addr[2]`, with `bus_addr[1:0]` ignored. For a shared ID, a read of the lower word returns `{40'b0, affinity}` on `rd_data` in the cycle after the request.
- R3: On an accepted write only `bus_wdata[23:0]` is stored. Bits 63:24 of `rd_data` are always zero.
- R4: A 32-bit access (`bus_wide`=0) with `bus_addr[2]`=1 targets the upper word. Such a write changes no entry and no route output, and such a read returns 0.
- R5: A 64-bit access (`bus_wide`=1) ignores `bus_addr[2]`. Its write stores `bus_wdata[23:0]`, and its read returns the same value as a lower-word read.
- R6: IDs below `PRIV_IRQ` and IDs at or above `NUM_IRQ` read as 0. Writes to them change no entry and no route output.
- R7: On the clock edge that stores a written affinity, the route of that interrupt is updated. `route_cpu[s]` becomes the lowest processor index `i` whose table slot `cpu_aff_table[i*24 +: 24]` equals the affinity, and `route_ok[s]` becomes 1. Here `s` = ID − `PRIV_IRQ`.
- R8: When no table slot matches a written affinity, `route_ok[s]` becomes 0 and `route_cpu[s]` becomes 0.
- R9: A write changes the route outputs of the addressed interrupt only.
- R10: `rd_valid` is 1 exactly in the cycle after a read request and 0 at all other times.
- R11: The table is sampled only at write time. Changing `cpu_aff_table` without a write leaves every route output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | ADDR_W | Byte offset in the region (ID * 8 + word * 4) |
| bus_wdata | input | 64 | Write data; a 32-bit write uses the low half |
| cpu_aff_table | input | NUM_CPU*24 | Affinity of processor i in bits [i*24 +: 24] |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Registered read data |
| route_cpu | output | NUM_SPI*CPU_W | Target index of shared interrupt s in [s*CPU_W +: CPU_W] |
| route_ok | output | NUM_SPI | Bit s set when shared interrupt s resolved to a processor |

## Verification
The bench builds the block with `NUM_IRQ`=48, `PRIV_IRQ`=32 and `NUM_CPU`=3. This gives 16 shared entries, and the 9-bit address then still reaches IDs 48 to 63, so out-of-range writes and reads can be driven. A processor count that is not a power of two leaves one index code unused. The bench loads the table with duplicate affinities, which exercises the lowest-index priority. A small pool of table values keeps the random writes split between hits and misses. Table changes made between writes show that the routes stay put until the next write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int AFF_W        = 24;
  localparam int BUS_W        = 64;
  localparam int WORD_SEL_BIT = 2;
  localparam int ENTRY_SHIFT  = 3;

  typedef enum logic {
    ACC_32 = 1'b0,
    ACC_64 = 1'b1
  } acc_size_e;
endpackage

// File: rtl/route_addr_decode.sv
module route_addr_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int PRIV_IRQ = 32,
  parameter int ADDR_W   = 9,
  parameter int SPI_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic              shared_hit,
  output logic              low_word,
  output logic [SPI_W-1:0]  slot
);
  localparam int ID_W = ADDR_W - ENTRY_SHIFT;

  logic [ID_W-1:0] id;
  logic [ID_W-1:0] rel;
  acc_size_e       size;
  logic            unused_bits;

  assign size        = acc_size_e'(wide);
  assign id          = addr[ADDR_W-1:ENTRY_SHIFT];
  assign rel         = id - ID_W'(PRIV_IRQ);
  assign shared_hit  = (int'(id) >= PRIV_IRQ) && (int'(id) < NUM_IRQ);
  assign low_word    = (size == ACC_64) || !addr[WORD_SEL_BIT];
  assign slot        = rel[SPI_W-1:0];
  assign unused_bits = ^{addr[1:0], rel};
endmodule

// File: rtl/aff_lookup.sv
module aff_lookup
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input  logic [AFF_W-1:0]         key,
  input  logic [NUM_CPU*AFF_W-1:0] aff_tab,
  output logic                     hit,
  output logic [CPU_W-1:0]         idx
);
  logic [NUM_CPU-1:0] eq;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cmp
    assign eq[g] = (aff_tab[g*AFF_W +: AFF_W] == key);
  end

  // Lowest matching processor index wins.
  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = NUM_CPU - 1; i >= 0; i--) begin
      if (eq[i]) idx = CPU_W'(i);
    end
  end
endmodule

// File: rtl/route_store.sv
module route_store
  import irq_route_pkg::*;
#(
  parameter int NUM_SPI = 32,
  parameter int SPI_W   = 5,
  parameter int CPU_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [SPI_W-1:0]         wr_slot,
  input  logic [AFF_W-1:0]         wr_aff,
  input  logic                     wr_hit,
  input  logic [CPU_W-1:0]         wr_idx,
  input  logic                     rd_en,
  input  logic                     rd_sel_ok,
  input  logic [SPI_W-1:0]         rd_slot,
  output logic                     rd_valid,
  output logic [BUS_W-1:0]         rd_data,
  output logic [NUM_SPI*CPU_W-1:0] route_cpu,
  output logic [NUM_SPI-1:0]       route_ok
);
  logic [AFF_W-1:0] aff_mem [NUM_SPI];
  logic [CPU_W-1:0] cpu_q   [NUM_SPI];
  logic [NUM_SPI-1:0] ok_q;

  // Affinity and resolved route commit on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SPI; i++) begin
        aff_mem[i] <= '0;
        cpu_q[i]   <= '0;
      end
      ok_q <= '0;
    end else if (wr_en) begin
      aff_mem[wr_slot] <= wr_aff;
      cpu_q[wr_slot]   <= wr_hit ? wr_idx : '0;
      ok_q[wr_slot]    <= wr_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= rd_sel_ok ? {{(BUS_W-AFF_W){1'b0}}, aff_mem[rd_slot]} : '0;
      end
    end
  end

  for (genvar g = 0; g < NUM_SPI; g++) begin : g_flat
    assign route_cpu[g*CPU_W +: CPU_W] = cpu_q[g];
  end
  assign route_ok = ok_q;
endmodule

// File: rtl/irq_affinity_router.sv
module irq_affinity_router
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int PRIV_IRQ = 32,
  parameter int NUM_CPU  = 4,
  localparam int NUM_SPI = NUM_IRQ - PRIV_IRQ,
  localparam int ADDR_W  = $clog2(NUM_IRQ * 8),
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SPI_W   = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic                     bus_wide,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [63:0]              bus_wdata,
  input  logic [NUM_CPU*24-1:0]    cpu_aff_table,
  output logic                     rd_valid,
  output logic [63:0]              rd_data,
  output logic [NUM_SPI*CPU_W-1:0] route_cpu,
  output logic [NUM_SPI-1:0]       route_ok
);
  logic             shared_hit;
  logic             low_word;
  logic [SPI_W-1:0] slot;
  logic             match_hit;
  logic [CPU_W-1:0] match_idx;
  logic             wr_en;
  logic             rd_en;
  logic             unused_wdata;

  route_addr_decode #(
    .NUM_IRQ (NUM_IRQ),
    .PRIV_IRQ(PRIV_IRQ),
    .ADDR_W  (ADDR_W),
    .SPI_W   (SPI_W)
  ) u_dec (
    .addr      (bus_addr),
    .wide      (bus_wide),
    .shared_hit(shared_hit),
    .low_word  (low_word),
    .slot      (slot)
  );

  aff_lookup #(
    .NUM_CPU(NUM_CPU),
    .CPU_W  (CPU_W)
  ) u_look (
    .key    (bus_wdata[AFF_W-1:0]),
    .aff_tab(cpu_aff_table),
    .hit    (match_hit),
    .idx    (match_idx)
  );

  assign wr_en        = bus_valid && bus_write && shared_hit && low_word;
  assign rd_en        = bus_valid && !bus_write;
  assign unused_wdata = ^bus_wdata[BUS_W-1:AFF_W];

  route_store #(
    .NUM_SPI(NUM_SPI),
    .SPI_W  (SPI_W),
    .CPU_W  (CPU_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_slot  (slot),
    .wr_aff   (bus_wdata[AFF_W-1:0]),
    .wr_hit   (match_hit),
    .wr_idx   (match_idx),
    .rd_en    (rd_en),
    .rd_sel_ok(shared_hit && low_word),
    .rd_slot  (slot),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .route_cpu(route_cpu),
    .route_ok (route_ok)
  );
endmodule

// File: rtl/route_checker.sv
module route_checker #(
  parameter int NUM_IRQ  = 64,
  parameter int PRIV_IRQ = 32,
  parameter int NUM_CPU  = 4,
  localparam int NUM_SPI = NUM_IRQ - PRIV_IRQ,
  localparam int ADDR_W  = $clog2(NUM_IRQ * 8),
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_valid,
  input logic                     bus_write,
  input logic                     bus_wide,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     rd_valid,
  input logic [63:0]              rd_data,
  input logic [NUM_SPI*CPU_W-1:0] route_cpu,
  input logic [NUM_SPI-1:0]       route_ok
);
  logic [ADDR_W-4:0] id;
  logic              is_rd;
  logic              is_wr;
  assign id    = bus_addr[ADDR_W-1:3];
  assign is_rd = bus_valid && !bus_write;
  assign is_wr = bus_valid && bus_write;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (route_ok == '0 && route_cpu == '0));

  assert_rd_hi_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_data[63:24] == '0);

  assert_upper_read_R4: assert property (@(posedge clk) disable iff (rst)
    (is_rd && !bus_wide && bus_addr[2]) |=> rd_data == '0);

  assert_upper_write_R4: assert property (@(posedge clk) disable iff (rst)
    (is_wr && !bus_wide && bus_addr[2]) |=> ($stable(route_ok) && $stable(route_cpu)));

  assert_private_R6: assert property (@(posedge clk) disable iff (rst)
    (is_wr && int'(id) < PRIV_IRQ) |=> ($stable(route_ok) && $stable(route_cpu)));

  assert_rd_valid_R10: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> rd_valid);

  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> !rd_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !is_wr |=> ($stable(route_ok) && $stable(route_cpu)));

  for (genvar g = 0; g < NUM_SPI; g++) begin : g_miss
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
      !route_ok[g] |-> route_cpu[g*CPU_W +: CPU_W] == '0);
  end
endmodule

bind irq_affinity_router route_checker #(
  .NUM_IRQ (NUM_IRQ),
  .PRIV_IRQ(PRIV_IRQ),
  .NUM_CPU (NUM_CPU)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .bus_wide (bus_wide),
  .bus_addr (bus_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .route_cpu(route_cpu),
  .route_ok (route_ok)
);

// File: tb/sim_irq_affinity_router.sv
`timescale 1ns/1ps
module sim_irq_affinity_router;
  localparam int NI = 48;
  localparam int PI = 32;
  localparam int NC = 3;
  localparam int NS = NI - PI;
  localparam int AW = 9;
  localparam int CW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_valid = 1'b0;
  logic           bus_write = 1'b0;
  logic           bus_wide = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [63:0]    bus_wdata = '0;
  logic [NC*24-1:0] cpu_aff_table;
  logic           rd_valid;
  logic [63:0]    rd_data;
  logic [NS*CW-1:0] route_cpu;
  logic [NS-1:0]  route_ok;

  logic [23:0] tab [NC];
  logic [23:0] m_aff [64];
  bit          m_ok [NS];
  int          m_cpu [NS];
  int n_checks = 0;
  int n_errs = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NC; i++) cpu_aff_table[i*24 +: 24] = tab[i];
  end

  irq_affinity_router #(.NUM_IRQ(NI), .PRIV_IRQ(PI), .NUM_CPU(NC)) u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cpu_aff_table(cpu_aff_table), .rd_valid(rd_valid), .rd_data(rd_data),
    .route_cpu(route_cpu), .route_ok(route_ok)
  );

  task automatic chk(input bit pass, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!pass) begin
      n_errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lookup(input logic [23:0] a);
    for (int i = 0; i < NC; i++) if (tab[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [63:0] exp_read(input int id, input bit word, input bit wide);
    if (id >= PI && id < NI && (wide || !word)) return {40'b0, m_aff[id]};
    return 64'b0;
  endfunction

  task automatic check_routes(input string req);
    for (int s = 0; s < NS; s++) begin
      chk(route_ok[s] == m_ok[s], req, "route_ok", 64'(route_ok[s]), 64'(m_ok[s]));
      chk(int'(route_cpu[s*CW +: CW]) == m_cpu[s], req, "route_cpu",
          64'(route_cpu[s*CW +: CW]), 64'(m_cpu[s]));
    end
  endtask

  task automatic wr(input int id, input bit word, input bit wide,
                    input logic [63:0] data, input string req);
    int k;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_wide = wide;
    bus_addr = AW'(id * 8 + (word ? 4 : 0)); bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (id >= PI && id < NI && (wide || !word)) begin
      m_aff[id] = data[23:0];
      k = lookup(data[23:0]);
      m_ok[id-PI] = (k >= 0);
      m_cpu[id-PI] = (k >= 0) ? k : 0;
    end
    chk(rd_valid == 1'b0, "R10", "rd_valid after write", 64'(rd_valid), 64'd0);
    check_routes(req);
  endtask

  task automatic rd(input int id, input bit word, input bit wide, input string req);
    logic [63:0] e;
    e = exp_read(id, word, wide);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_wide = wide;
    bus_addr = AW'(id * 8 + (word ? 4 : 0)) | AW'($urandom_range(0, 3));
    @(negedge clk);
    bus_valid = 1'b0;
    chk(rd_valid == 1'b1, "R10", "rd_valid after read", 64'(rd_valid), 64'd1);
    chk(rd_data == e, req, "rd_data", rd_data, e);
  endtask

  function automatic logic [23:0] pick_aff();
    if ($urandom_range(0, 1) == 0) return tab[$urandom_range(0, NC-1)];
    return 24'($urandom);
  endfunction

  initial begin
    #(5.0 * 200000);
    n_errs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) m_aff[i] = '0;
    for (int s = 0; s < NS; s++) begin m_ok[s] = 0; m_cpu[s] = 0; end
    tab[0] = 24'h000100; tab[1] = 24'h010203; tab[2] = 24'h010203;

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    chk(rd_valid == 1'b0, "R10", "rd_valid idle", 64'(rd_valid), 64'd0);
    check_routes("R1");
    rd(32, 0, 0, "R1");
    rd(47, 0, 1, "R1");

    // R2 R3 R7: lower-word write, duplicate table entries -> lowest index
    wr(32, 0, 0, 64'hFFFF_FFFF_AB01_0203, "R7");
    rd(32, 0, 0, "R2");
    rd(32, 1, 0, "R4");
    chk(route_cpu[0 +: CW] == 2'd1, "R7", "priority index", 64'(route_cpu[0 +: CW]), 64'd1);

    // R5: 64-bit access ignores word bit
    wr(47, 1, 1, 64'hFFFF_FFFF_FF00_0100, "R5");
    rd(47, 1, 1, "R5");
    rd(47, 0, 0, "R3");

    // R4: upper-word write ignored
    wr(33, 1, 0, 64'h0000_0000_0001_0203, "R4");
    rd(33, 0, 0, "R4");

    // R6: private and out-of-range IDs
    wr(5, 0, 1, 64'h0000_0000_0001_0203, "R6");
    rd(5, 0, 1, "R6");
    wr(60, 0, 0, 64'h0000_0000_0000_0100, "R6");
    rd(60, 0, 0, "R6");

    // R8: miss
    wr(40, 0, 0, 64'h0000_0000_0012_3456, "R8");
    chk(route_ok[8] == 1'b0, "R8", "miss flag", 64'(route_ok[8]), 64'd0);

    // R11: table change without write leaves routes alone
    tab[2] = 24'h123456;
    repeat (3) @(negedge clk);
    check_routes("R11");
    wr(40, 0, 1, 64'h0000_0000_0012_3456, "R7");
    chk(route_cpu[8*CW +: CW] == 2'd2, "R7", "rematch", 64'(route_cpu[8*CW +: CW]), 64'd2);

    // R9: random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      int id;
      op = int'($urandom_range(0, 9));
      id = int'($urandom_range(0, 63));
      if (op < 5) begin
        wr(id, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           {32'($urandom), 8'($urandom), pick_aff()}, "R9");
      end else if (op < 9) begin
        rd(id, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "R2");
      end else begin
        tab[$urandom_range(0, NC-1)] = ($urandom_range(0, 1) == 0) ? 24'h000100 : 24'($urandom);
        @(negedge clk);
        check_routes("R11");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule